// File: doc/BRIEF.md
# Grouped Temperature Trip Monitor

The block receives readings from a set of on-die temperature sensors. The sensors are split into equal-sized groups, and each group is watched as one zone. A reading is a signed two's-complement number whose least significant bit is half a degree Celsius. A reading is taken in on the cycle its valid strobe is high. The zone temperature of a group is the largest of its member readings. Only sensors that have delivered at least one valid reading since reset take part in it.

Each group has a small set of rising trip levels and one hysteresis margin, all written through a single-cycle write port. When the zone temperature reaches a level that is armed, the block produces exactly one pulse for that level and disarms it. The level becomes armed again only after the temperature has dropped strictly below the level minus the margin. When one update crosses several levels at once, their pulses come out on consecutive cycles, lowest level first.

Beside the programmable levels, two thresholds are fixed at build time. The throttle request of a group follows the zone temperature above the first one. The shutdown request is set once any zone goes above the second one, and it then stays set until the block is reset.

Top module: `thermal_trip_monitor`

## Requirements
- R1: The zone temperature of group g is the signed maximum of the latest readings of sensors g*SENS_PER_GROUP to g*SENS_PER_GROUP+SENS_PER_GROUP-1. A sensor whose valid strobe has never been high since reset takes no part in it, whatever value sits on its data lines. A group with no such sensor produces no trip, throttle or shutdown.
- R2: Readings, levels and thresholds are TEMP_W-bit two's-complement values in half-degree steps, and every comparison is signed. For example, -20 (-10 °C) is below 0.
- R3: An armed level k of group g fires when the zone temperature is greater than or equal to the level. Firing disarms the level and produces exactly one one-cycle pulse on trip_pulse[g*LEVELS+k]. A level that is not armed produces no pulse, however long the temperature stays above it.
- R4: A disarmed level re-arms only when the zone temperature is strictly below level minus hysteresis. A temperature equal to that point does not re-arm it.
- R5: When several levels of one group have a pulse pending, one pulse is issued per cycle, lowest level index first. No pending pulse is lost.
- R6: throttle_req[g] is high while the zone temperature of group g is strictly greater than THROTTLE_LIM, and it is low otherwise. It appears one cycle after the zone temperature changes.
- R7: shutdown_req is set when any zone temperature is strictly greater than SHUTDOWN_LIM. Once set, it stays high until reset, even when the temperature falls.
- R8: A write with cfg_we high targets group cfg_addr[ADDR_W-1:SLOT_W] and slot cfg_addr[SLOT_W-1:0]. A slot below LEVELS holds the trip level of that index, and slot LEVELS holds the group hysteresis, which is unsigned. Writing a level arms it and discards any pulse pending for it. The level then fires on the next cycle if the temperature is already at or above the new value.
- R9: While rst_n is low at a clock edge, all outputs go low, every level is set to the most positive code and armed, every hysteresis is set to 0, and all sensors count as never seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sens_valid | input | GROUPS*SENS_PER_GROUP | Per-sensor strobe, reading taken when high |
| sens_temp | input | GROUPS*SENS_PER_GROUP*TEMP_W | Sensor readings, sensor i at bits i*TEMP_W upward |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W | Group in upper bits, slot in lower SLOT_W bits |
| cfg_wdata | input | TEMP_W | Level (signed) or hysteresis (unsigned) value |
| trip_pulse | output | GROUPS*LEVELS | One-cycle trip pulse, bit g*LEVELS+k |
| throttle_req | output | GROUPS | Throttle request per group |
| shutdown_req | output | 1 | Sticky shutdown request |

## Verification
The bench builds the block with two groups of three sensors and three levels per group. With three levels, one update can cross every level of a group at once, so the lowest-first ordering of pulses on successive cycles can be observed. Two groups allow one group to hold unseen sensors with large values on their data lines while the other group is driven, and they allow a negative level to be tried on its own. The default thresholds of 188 and 192 half-degrees are kept, so that readings of exactly 188 and 192 test the strict comparisons.

// File: rtl/tmon_pkg.sv
// Shared definitions for the grouped temperature trip monitor.
// Assumes slot numbers are small unsigned indices.
package tmon_pkg;

    // Kind of register a configuration slot selects
    typedef enum logic [1:0] {
        SLOT_LEVEL,
        SLOT_HYST,
        SLOT_NONE
    } slot_kind_e;

    // Map a slot index to the register kind it addresses
    function automatic slot_kind_e slot_kind(input int unsigned slot, input int unsigned levels);
        if (slot < levels) begin
            return SLOT_LEVEL;
        end else if (slot == levels) begin
            return SLOT_HYST;
        end
        return SLOT_NONE;
    endfunction

endpackage

// File: rtl/tmon_sensor_max.sv
// Captures the latest valid reading of each sensor in one group and forms
// the signed maximum over the sensors seen since reset.
// Assumes readings are TEMP_W-bit two's complement.
module tmon_sensor_max #(
    parameter int TEMP_W = 10,
    parameter int NSENS  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSENS-1:0]           valid,
    input  logic [NSENS*TEMP_W-1:0]    temps,
    output logic signed [TEMP_W-1:0]   gmax,
    output logic                       any_seen
);

    localparam logic signed [TEMP_W-1:0] MOST_NEG = {1'b1, {(TEMP_W-1){1'b0}}};

    logic signed [TEMP_W-1:0] rd_q [NSENS];
    logic [NSENS-1:0]         seen_q;

    // Hold each sensor's latest strobed reading and remember it was seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            for (int i = 0; i < NSENS; i++) begin
                rd_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NSENS; i++) begin
                if (valid[i]) begin
                    rd_q[i]   <= temps[i*TEMP_W +: TEMP_W];
                    seen_q[i] <= 1'b1;
                end
            end
        end
    end

    // Signed maximum over the seen sensors only
    always_comb begin
        gmax = MOST_NEG;
        for (int i = 0; i < NSENS; i++) begin
            if (seen_q[i] && (rd_q[i] > gmax)) begin
                gmax = rd_q[i];
            end
        end
    end

    assign any_seen = |seen_q;

    for (genvar i = 0; i < NSENS; i++) begin : g_max_chk
        // R1
        max_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seen_q[i] |-> (gmax >= rd_q[i]));
    end

endmodule

// File: rtl/tmon_trip_level.sv
// One programmable rising trip level with edge firing and hysteresis
// re-arm. Holds the level register, the armed flag and a pending pulse.
// Assumes hyst is an unsigned magnitude in the same steps as temp.
module tmon_trip_level #(
    parameter int TEMP_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     temp_ok,
    input  logic signed [TEMP_W-1:0] temp,
    input  logic [TEMP_W-1:0]        hyst,
    input  logic                     lvl_wr,
    input  logic [TEMP_W-1:0]        lvl_wdata,
    input  logic                     issue,
    output logic                     pend
);

    localparam int XW = TEMP_W + 2;
    localparam logic signed [TEMP_W-1:0] MOST_POS = {1'b0, {(TEMP_W-1){1'b1}}};

    logic signed [TEMP_W-1:0] level_q;
    logic                     armed_q;
    logic                     pend_q;
    logic signed [XW-1:0]     temp_x;
    logic signed [XW-1:0]     rearm_x;
    logic                     fire;
    logic                     rearm;

    // Widen so that level minus hysteresis cannot wrap
    assign temp_x  = {{2{temp[TEMP_W-1]}}, temp};
    assign rearm_x = {{2{level_q[TEMP_W-1]}}, level_q} - {2'b00, hyst};
    assign fire    = temp_ok && armed_q && (temp >= level_q);
    assign rearm   = temp_ok && !armed_q && (temp_x < rearm_x);

    // Level register, written from the configuration port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= MOST_POS;
        end else if (lvl_wr) begin
            level_q <= lvl_wdata;
        end
    end

    // Armed and pending state; a rewrite re-arms and drops the pending pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            pend_q  <= 1'b0;
        end else if (lvl_wr) begin
            armed_q <= 1'b1;
            pend_q  <= 1'b0;
        end else begin
            if (fire) begin
                armed_q <= 1'b0;
            end else if (rearm) begin
                armed_q <= 1'b1;
            end
            pend_q <= (pend_q && !issue) || fire;
        end
    end

    assign pend = pend_q;

    // R5
    pend_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !issue && !lvl_wr) |=> pend_q);

    // R4
    rearm_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(armed_q) && !$past(lvl_wr)) |-> $past(temp_ok && (temp_x < rearm_x)));

    // R3
    fire_needs_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pend_q) && !$past(lvl_wr)) |-> $past(temp_ok && (temp >= level_q) && armed_q));

endmodule

// File: rtl/tmon_group.sv
// One sensor group: zone maximum, hysteresis register, trip levels,
// a lowest-first pulse arbiter and the fixed throttle and shutdown compares.
// Assumes cfg_sel is high only for a write aimed at this group.
module tmon_group
    import tmon_pkg::*;
#(
    parameter int TEMP_W         = 10,
    parameter int SENS_PER_GROUP = 2,
    parameter int LEVELS         = 3,
    parameter int THROTTLE_LIM   = 188,
    parameter int SHUTDOWN_LIM   = 192,
    parameter int SLOT_W         = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [SENS_PER_GROUP-1:0]          sens_valid,
    input  logic [SENS_PER_GROUP*TEMP_W-1:0]   sens_temp,
    input  logic                               cfg_sel,
    input  logic [SLOT_W-1:0]                  cfg_slot,
    input  logic [TEMP_W-1:0]                  cfg_wdata,
    output logic [LEVELS-1:0]                  pulse,
    output logic                               throttle,
    output logic                               shutdown
);

    localparam logic signed [TEMP_W-1:0] THR_C = TEMP_W'(THROTTLE_LIM);
    localparam logic signed [TEMP_W-1:0] SDN_C = TEMP_W'(SHUTDOWN_LIM);

    logic signed [TEMP_W-1:0] gmax;
    logic                     any_seen;
    logic [TEMP_W-1:0]        hyst_q;
    logic [LEVELS-1:0]        pend;
    logic [LEVELS-1:0]        issue;
    logic [LEVELS-1:0]        pulse_q;
    logic                     thr_q;
    logic                     sdn_q;
    slot_kind_e               kind;

    tmon_sensor_max #(
        .TEMP_W (TEMP_W),
        .NSENS  (SENS_PER_GROUP)
    ) i_max (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (sens_valid),
        .temps    (sens_temp),
        .gmax     (gmax),
        .any_seen (any_seen)
    );

    assign kind = slot_kind(32'(cfg_slot), LEVELS);

    // Group hysteresis register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hyst_q <= '0;
        end else if (cfg_sel && (kind == SLOT_HYST)) begin
            hyst_q <= cfg_wdata;
        end
    end

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        logic wr_k;
        assign wr_k = cfg_sel && (kind == SLOT_LEVEL) && (cfg_slot == SLOT_W'(k));

        tmon_trip_level #(
            .TEMP_W (TEMP_W)
        ) i_lvl (
            .clk       (clk),
            .rst_n     (rst_n),
            .temp_ok   (any_seen),
            .temp      (gmax),
            .hyst      (hyst_q),
            .lvl_wr    (wr_k),
            .lvl_wdata (cfg_wdata),
            .issue     (issue[k]),
            .pend      (pend[k])
        );
    end

    // Lowest pending level wins this cycle
    assign issue = pend & (~pend + LEVELS'(1));

    // Register the issued pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
        end else begin
            pulse_q <= issue;
        end
    end

    // Throttle follows the zone temperature, shutdown is sticky
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= 1'b0;
            sdn_q <= 1'b0;
        end else begin
            thr_q <= any_seen && (gmax > THR_C);
            sdn_q <= sdn_q || (any_seen && (gmax > SDN_C));
        end
    end

    assign pulse    = pulse_q;
    assign throttle = thr_q;
    assign shutdown = sdn_q;

    // R5
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_q));

    for (genvar k = 1; k < LEVELS; k++) begin : g_order
        localparam logic [LEVELS-1:0] LOWER = LEVELS'((1 << k) - 1);
        // R5
        lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_q[k] |-> (($past(pend) & LOWER) == '0));
    end

endmodule

// File: rtl/thermal_trip_monitor.sv
// Top level: splits sensors into groups, decodes the configuration write
// and merges the per-group shutdown flags into one sticky request.
// Assumes sensors of group g occupy consecutive indices.
module thermal_trip_monitor #(
    parameter int GROUPS         = 3,
    parameter int SENS_PER_GROUP = 2,
    parameter int LEVELS         = 3,
    parameter int TEMP_W         = 10,
    parameter int THROTTLE_LIM   = 188,
    parameter int SHUTDOWN_LIM   = 192,
    localparam int NSENS         = GROUPS * SENS_PER_GROUP,
    localparam int SLOT_W        = $clog2(LEVELS + 1),
    localparam int GRP_W         = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int ADDR_W        = GRP_W + SLOT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSENS-1:0]           sens_valid,
    input  logic [NSENS*TEMP_W-1:0]    sens_temp,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [TEMP_W-1:0]          cfg_wdata,
    output logic [GROUPS*LEVELS-1:0]   trip_pulse,
    output logic [GROUPS-1:0]          throttle_req,
    output logic                       shutdown_req
);

    logic [GRP_W-1:0]  cfg_grp;
    logic [SLOT_W-1:0] cfg_slot;
    logic [GROUPS-1:0] grp_sdn;

    assign cfg_grp  = cfg_addr[ADDR_W-1:SLOT_W];
    assign cfg_slot = cfg_addr[SLOT_W-1:0];

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic sel_g;
        assign sel_g = cfg_we && (cfg_grp == GRP_W'(g));

        tmon_group #(
            .TEMP_W         (TEMP_W),
            .SENS_PER_GROUP (SENS_PER_GROUP),
            .LEVELS         (LEVELS),
            .THROTTLE_LIM   (THROTTLE_LIM),
            .SHUTDOWN_LIM   (SHUTDOWN_LIM),
            .SLOT_W         (SLOT_W)
        ) i_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .sens_valid (sens_valid[g*SENS_PER_GROUP +: SENS_PER_GROUP]),
            .sens_temp  (sens_temp[g*SENS_PER_GROUP*TEMP_W +: SENS_PER_GROUP*TEMP_W]),
            .cfg_sel    (sel_g),
            .cfg_slot   (cfg_slot),
            .cfg_wdata  (cfg_wdata),
            .pulse      (trip_pulse[g*LEVELS +: LEVELS]),
            .throttle   (throttle_req[g]),
            .shutdown   (grp_sdn[g])
        );
    end

    assign shutdown_req = |grp_sdn;

    // R7
    shutdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |=> shutdown_req);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (trip_pulse == '0) && (throttle_req == '0) && !shutdown_req);

endmodule

// File: tb/test_thermal_trip_monitor.sv
`timescale 1ns/1ps
module test_thermal_trip_monitor;

    localparam int G  = 2;
    localparam int SP = 3;
    localparam int L  = 3;
    localparam int W  = 10;
    localparam int NS = G * SP;
    localparam int AW = 1 + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     sens_valid = '0;
    logic [NS*W-1:0]   sens_temp = '0;
    logic              cfg_we = 1'b0;
    logic [AW-1:0]     cfg_addr = '0;
    logic [W-1:0]      cfg_wdata = '0;
    logic [G*L-1:0]    trip_pulse;
    logic [G-1:0]      throttle_req;
    logic              shutdown_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int cyc = 0;
    int lg_idx [64];
    int lg_cyc [64];
    int lg_n = 0;

    thermal_trip_monitor #(
        .GROUPS(G), .SENS_PER_GROUP(SP), .LEVELS(L), .TEMP_W(W),
        .THROTTLE_LIM(188), .SHUTDOWN_LIM(192)
    ) i_thermal_trip_monitor (
        .clk(clk), .rst_n(rst_n), .sens_valid(sens_valid), .sens_temp(sens_temp),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .trip_pulse(trip_pulse), .throttle_req(throttle_req), .shutdown_req(shutdown_req)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Log every pulse with the cycle it was seen in
    always @(negedge clk) begin
        for (int k = 0; k < G*L; k++) begin
            if (trip_pulse[k] && lg_n < 64) begin
                lg_idx[lg_n] = k;
                lg_cyc[lg_n] = cyc;
                lg_n = lg_n + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(posedge clk);
        #1 lg_n = 0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic cfg_write(input int grp, input int slot, input int val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(grp * 4 + slot);
        cfg_wdata = W'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put(input int idx, input int t);
        @(negedge clk);
        sens_temp[idx*W +: W] = W'(t);
        sens_valid[idx] = 1'b1;
        @(negedge clk);
        sens_valid = '0;
        settle();
    endtask

    task automatic put_grp(input int grp, input int t);
        @(negedge clk);
        for (int i = 0; i < SP; i++) begin
            sens_temp[(grp*SP+i)*W +: W] = W'(t);
            sens_valid[grp*SP+i] = 1'b1;
        end
        @(negedge clk);
        sens_valid = '0;
        settle();
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R9 pulses in reset", int'(trip_pulse), 0);
        chk("R9 throttle in reset", int'(throttle_req), 0);
        chk("R9 shutdown in reset", int'(shutdown_req), 0);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_unseen();
        for (int i = 3; i < 6; i++) sens_temp[i*W +: W] = W'(300);
        cfg_write(1, 0, 100);
        clear_log();
        put(3, 50);
        chk("R1 unseen sensors ignored, pulses", lg_n, 0);
        chk("R1 unseen sensors ignored, throttle", int'(throttle_req[1]), 0);
    endtask

    task automatic t_max();
        cfg_write(0, 0, 100);
        cfg_write(0, 1, 110);
        cfg_write(0, 2, 120);
        cfg_write(0, 3, 2);
        clear_log();
        put(0, 80);
        put(1, 105);
        put(2, 60);
        chk("R1 group max pulse count", lg_n, 1);
        chk("R3 pulse index", lg_idx[0], 0);
    endtask

    task automatic t_hyst();
        clear_log();
        put_grp(0, 99);
        put_grp(0, 105);
        chk("R3 no refire above rearm point", lg_n, 0);
        put_grp(0, 98);
        put_grp(0, 105);
        chk("R4 equal to rearm point keeps disarmed", lg_n, 0);
        put_grp(0, 97);
        put_grp(0, 105);
        chk("R4 below rearm point refires", lg_n, 1);
        chk("R4 refire index", lg_idx[0], 0);
    endtask

    task automatic t_multi();
        put_grp(0, 90);
        clear_log();
        put_grp(0, 125);
        chk("R5 multi cross pulse count", lg_n, 3);
        chk("R5 first is level 0", lg_idx[0], 0);
        chk("R5 second is level 1", lg_idx[1], 1);
        chk("R5 third is level 2", lg_idx[2], 2);
        chk("R5 consecutive cycles", lg_cyc[2] - lg_cyc[0], 2);
    endtask

    task automatic t_rewrite();
        clear_log();
        cfg_write(0, 2, 122);
        settle();
        chk("R8 rewrite rearms, count", lg_n, 1);
        chk("R8 rewrite rearms, index", lg_idx[0], 2);
    endtask

    task automatic t_negative();
        put(3, -30);
        cfg_write(1, 0, -20);
        clear_log();
        settle();
        chk("R2 -30 below -20 no pulse", lg_n, 0);
        put(3, -20);
        chk("R2 negative level pulse count", lg_n, 1);
        chk("R2 negative level index", lg_idx[0], 3);
    endtask

    task automatic t_throttle();
        put_grp(0, 188);
        chk("R6 throttle at limit", int'(throttle_req[0]), 0);
        put_grp(0, 189);
        chk("R6 throttle above limit", int'(throttle_req[0]), 1);
        chk("R6 other group unaffected", int'(throttle_req[1]), 0);
        put_grp(0, 150);
        chk("R6 throttle released", int'(throttle_req[0]), 0);
    endtask

    task automatic t_shutdown();
        put_grp(0, 192);
        chk("R7 shutdown at limit", int'(shutdown_req), 0);
        put_grp(0, 193);
        chk("R7 shutdown above limit", int'(shutdown_req), 1);
        put_grp(0, 100);
        chk("R7 shutdown sticky", int'(shutdown_req), 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 shutdown cleared by reset", int'(shutdown_req), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_unseen();
        t_max();
        t_hyst();
        t_multi();
        t_rewrite();
        t_negative();
        t_throttle();
        t_shutdown();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule